// File: doc/BRIEF.md
# Page Write Load Controller

This controller sits inside a byte-wide nonvolatile memory model and gathers single-byte writes into a page buffer before a self-timed programming cycle starts. The first write accepted while the controller is idle freezes the page address, which is the address bits above the in-page byte index. Each later write to that page drives the page-buffer write enable and marks its byte as valid. A write that names a different page is flagged and dropped.

No explicit commit command exists. An inactivity timer restarts on every accepted byte. When that timer runs out with no new accepted write, the controller emits a one-cycle start pulse and stays busy for a fixed programming time. During that time it ignores every write. When programming ends, the valid mask and the byte count are cleared and the controller is ready for the next page. Both the inactivity window and the programming time are parameters counted in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset the controller is idle: `load_active`, `prog_busy`, `prog_start`, `page_err` and `buf_we` are 0, `load_cnt` is 0 and `valid_mask` is all zero.
- R2: A write strobe seen while idle is accepted in the same cycle (`buf_we`=1). From the next cycle `load_active`=1 and `page_addr` holds `wr_addr[ADDR_W-1:PAGE_BITS]` of that write.
- R3: Each accepted write presents `buf_idx` = `wr_addr[PAGE_BITS-1:0]` and `buf_data` = `wr_data` with `buf_we`=1, and sets bit `buf_idx` of `valid_mask`. `load_cnt` counts distinct valid bytes, so rewriting a byte already valid does not raise it.
- R4: During a load, a write whose page bits differ from `page_addr` raises `page_err` in that cycle, gives no `buf_we`, changes neither `valid_mask` nor `load_cnt`, and does not restart the inactivity window.
- R5: A write accepted at most `WINDOW_CYC` clock edges after the previous accepted write extends the load. If `WINDOW_CYC` edges pass with no accepted write, programming begins after that edge.
- R6: The load has no overall time limit. It stays open for any number of windows as long as each gap stays inside the window.
- R7: `prog_start` is high for exactly one cycle, the first cycle of `prog_busy`, and `prog_busy` lasts exactly `PROG_CYC` cycles.
- R8: Writes during `prog_busy` are ignored: no `buf_we`, no `page_err`, no change to the mask. After programming, a new write may lock a different page.
- R9: When programming ends, `valid_mask` and `load_cnt` are cleared and the controller returns to idle.
- R10: A full page of 2^`PAGE_BITS` distinct bytes can be loaded, after which `load_cnt` equals the page size and every bit of `valid_mask` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write strobe, one byte per cycle it is high |
| wr_addr | input | ADDR_W | Byte address (page bits above, byte index below) |
| wr_data | input | DATA_W | Write data |
| buf_we | output | 1 | Page-buffer write enable |
| buf_idx | output | PAGE_BITS | Byte index within the page buffer |
| buf_data | output | DATA_W | Data for the page buffer |
| page_addr | output | ADDR_W-PAGE_BITS | Locked page address |
| valid_mask | output | 2^PAGE_BITS | One bit per loaded byte |
| load_cnt | output | PAGE_BITS+1 | Number of distinct bytes loaded |
| load_active | output | 1 | A page load is open |
| page_err | output | 1 | Write rejected for a page mismatch |
| prog_start | output | 1 | One-cycle pulse when programming starts |
| prog_busy | output | 1 | Programming cycle in progress |

## Verification
The bench builds the controller with `WINDOW_CYC`=20 and `PROG_CYC`=50. Those values are short enough to hit the last edge on which a write still extends a load, the edge on which a load times out, and the exact length of the busy period. The address and page widths keep their defaults, so a full 128-byte page, mismatches on the 8-bit page field, and chains of loads that outlast several windows all fit in a short run.

// File: rtl/plc_pkg.sv
// Shared types for the page write load controller.
package plc_pkg;
    typedef enum logic [1:0] {
        PLC_IDLE = 2'd0,
        PLC_LOAD = 2'd1,
        PLC_PROG = 2'd2
    } plc_state_e;
endpackage

// File: rtl/plc_cycle_timer.sv
// Restartable down-counter timer.
// A load sets the count to CYCLES-1. While run is high the count
// falls by one per cycle and stops at zero. zero is high when the count is 0.
// Assumes CYCLES >= 1.
module plc_cycle_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CNT_W-1:0] count;

    // Reload on demand, otherwise count down toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= CNT_W'(CYCLES - 1);
        else if (run && count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);
endmodule

// File: rtl/plc_page_track.sv
// Page lock, per-byte valid mask and distinct-byte counter.
// lock marks the first write of a load and captures the page.
// clear empties the mask and the counter. Assumes clear and accept
// are never high together.
module plc_page_track #(
    parameter int ADDR_W    = 15,
    parameter int PAGE_BITS = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic                        lock,
    input  logic                        clear,
    input  logic [ADDR_W-PAGE_BITS-1:0] pg_in,
    input  logic [PAGE_BITS-1:0]        idx,
    output logic [ADDR_W-PAGE_BITS-1:0] pg_q,
    output logic                        match,
    output logic [(1<<PAGE_BITS)-1:0]   mask,
    output logic [PAGE_BITS:0]          cnt
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    // Capture the page address on the opening write of a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pg_q <= '0;
        else if (accept && lock)
            pg_q <= pg_in;
    end

    assign match = (pg_in == pg_q);

    // One valid flag per byte slot of the page.
    for (genvar i = 0; i < PAGE_SIZE; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                mask[i] <= 1'b0;
            else if (accept && idx == PAGE_BITS'(i))
                mask[i] <= 1'b1;
        end
    end

    // Count a byte only the first time its slot becomes valid.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (accept && !mask[idx])
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/page_load_ctrl.sv
// Page write load controller.
// Collects byte writes to one page and starts programming after the
// inactivity window runs out. It then holds busy for PROG_CYC cycles.
// Assumes one byte per strobe cycle. Buffer storage lives outside.
module page_load_ctrl #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_BITS  = 7,
    parameter int WINDOW_CYC = 12500,
    parameter int PROG_CYC   = 625000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        buf_we,
    output logic [PAGE_BITS-1:0]        buf_idx,
    output logic [DATA_W-1:0]           buf_data,
    output logic [ADDR_W-PAGE_BITS-1:0] page_addr,
    output logic [(1<<PAGE_BITS)-1:0]   valid_mask,
    output logic [PAGE_BITS:0]          load_cnt,
    output logic                        load_active,
    output logic                        page_err,
    output logic                        prog_start,
    output logic                        prog_busy
);
    import plc_pkg::*;

    localparam int PG_W = ADDR_W - PAGE_BITS;

    plc_state_e          state_q;
    plc_state_e          state_d;
    logic [PG_W-1:0]     in_pg;
    logic [PAGE_BITS-1:0] in_idx;
    logic                pg_match;
    logic                accept;
    logic                expire;
    logic                prog_end;
    logic                win_zero;
    logic                prog_zero;

    assign in_pg  = wr_addr[ADDR_W-1:PAGE_BITS];
    assign in_idx = wr_addr[PAGE_BITS-1:0];

    // Decide acceptance, page errors, window expiry and programming end.
    always_comb begin
        accept   = wr_stb && (state_q == PLC_IDLE ||
                              (state_q == PLC_LOAD && pg_match));
        page_err = wr_stb && state_q == PLC_LOAD && !pg_match;
        expire   = state_q == PLC_LOAD && win_zero && !accept;
        prog_end = state_q == PLC_PROG && prog_zero;
    end

    // Next-state selection for idle, loading and programming.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PLC_IDLE: if (accept)   state_d = PLC_LOAD;
            PLC_LOAD: if (expire)   state_d = PLC_PROG;
            PLC_PROG: if (prog_end) state_d = PLC_IDLE;
            default:                state_d = PLC_IDLE;
        endcase
    end

    // State register and registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PLC_IDLE;
            prog_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            prog_start <= expire;
        end
    end

    plc_cycle_timer #(.CYCLES(WINDOW_CYC)) win_tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .run  (state_q == PLC_LOAD),
        .zero (win_zero)
    );

    plc_cycle_timer #(.CYCLES(PROG_CYC)) prog_tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (expire),
        .run  (state_q == PLC_PROG),
        .zero (prog_zero)
    );

    plc_page_track #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) track_i (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .lock  (state_q == PLC_IDLE),
        .clear (prog_end),
        .pg_in (in_pg),
        .idx   (in_idx),
        .pg_q  (page_addr),
        .match (pg_match),
        .mask  (valid_mask),
        .cnt   (load_cnt)
    );

    assign buf_we      = accept;
    assign buf_idx     = in_idx;
    assign buf_data    = wr_data;
    assign load_active = (state_q == PLC_LOAD);
    assign prog_busy   = (state_q == PLC_PROG);
endmodule

// File: rtl/plc_checker.sv
// Property checker for page_load_ctrl, attached with bind below.
// Window and busy lengths are checked with counters rather than long delays.
module plc_checker #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BITS  = 7,
    parameter int WINDOW_CYC = 12500,
    parameter int PROG_CYC   = 625000
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        buf_we,
    input logic                        page_err,
    input logic                        prog_start,
    input logic                        prog_busy,
    input logic                        load_active,
    input logic [ADDR_W-PAGE_BITS-1:0] page_addr,
    input logic [(1<<PAGE_BITS)-1:0]   valid_mask,
    input logic [PAGE_BITS:0]          load_cnt
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [31:0] gap_cnt;
    logic [31:0] busy_cnt;

    // Cycles since the last accepted byte while a load is open.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_we)
            gap_cnt <= '0;
        else if (load_active)
            gap_cnt <= gap_cnt + 1;
        else
            gap_cnt <= '0;
    end

    // Cycles spent busy in the current programming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !prog_busy)
            busy_cnt <= '0;
        else
            busy_cnt <= busy_cnt + 1;
    end

    AST_GAP_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_active |-> gap_cnt < WINDOW_CYC); // R5
    AST_ERR_NOT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |-> !buf_we); // R4
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && $past(load_active)) |-> $stable(page_addr)); // R2
    AST_CNT_EQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt == $countones(valid_mask)); // R3
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt <= PAGE_SIZE); // R10
    AST_START_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> prog_start); // R7
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> busy_cnt < PROG_CYC); // R7
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (!buf_we && !page_err && !load_active)); // R8
    AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> (load_cnt == '0 && valid_mask == '0)); // R9
endmodule

bind page_load_ctrl plc_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .WINDOW_CYC(WINDOW_CYC),
    .PROG_CYC  (PROG_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_we     (buf_we),
    .page_err   (page_err),
    .prog_start (prog_start),
    .prog_busy  (prog_busy),
    .load_active(load_active),
    .page_addr  (page_addr),
    .valid_mask (valid_mask),
    .load_cnt   (load_cnt)
);

// File: tb/page_load_ctrl_tb_top.sv
module page_load_ctrl_tb_top;
    localparam int W  = 20;
    localparam int P  = 50;
    localparam int PS = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_stb = 1'b0;
    logic [14:0]  wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         buf_we;
    logic [6:0]   buf_idx;
    logic [7:0]   buf_data;
    logic [7:0]   page_addr;
    logic [PS-1:0] valid_mask;
    logic [7:0]   load_cnt;
    logic         load_active;
    logic         page_err;
    logic         prog_start;
    logic         prog_busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int start_cyc = 0;
    logic [14:0] exp_q[$];

    page_load_ctrl #(.WINDOW_CYC(W), .PROG_CYC(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .page_addr(page_addr), .valid_mask(valid_mask),
        .load_cnt(load_cnt), .load_active(load_active), .page_err(page_err),
        .prog_start(prog_start), .prog_busy(prog_busy)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: every buffer write must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected write: actual %0d expected none", {buf_idx, buf_data});
            end else begin
                logic [14:0] item;
                item = exp_q.pop_front();
                if ({buf_idx, buf_data} != item) begin
                    n_fail++;
                    $display("FAIL R3 write item: actual %0h expected %0h", {buf_idx, buf_data}, item);
                end
            end
        end
    end

    // Driver: one strobe cycle. Called 2 ns after an edge; returns 2 ns after the sampling edge.
    task automatic wr(input logic [7:0] pg, input logic [6:0] ix, input logic [7:0] d,
                      input bit acc, input bit err, input string tag);
        wr_stb  = 1'b1;
        wr_addr = {pg, ix};
        wr_data = d;
        if (acc) exp_q.push_back({ix, d});
        @(negedge clk);
        chk(page_err == err, tag, page_err, err);
        @(posedge clk);
        #2;
        wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_busy_end();
        while (1) begin
            @(negedge clk);
            if (!prog_busy) break;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!load_active && !prog_busy && !prog_start && !page_err && !buf_we, "R1 idle flags",
            {load_active, prog_busy, prog_start, page_err, buf_we}, 0);
        chk(load_cnt == 0 && valid_mask == '0, "R1 counters", load_cnt, 0);
        @(posedge clk);
        #2;

        // R2 open a load on page 3
        wr(8'd3, 7'd5, 8'hA5, 1, 0, "R2");
        chk(load_active, "R2 load active", load_active, 1);
        chk(page_addr == 8'd3, "R2 page locked", page_addr, 3);
        chk(load_cnt == 1 && valid_mask[5], "R3 first byte", load_cnt, 1);
        // R3 second byte and rewrite of a valid byte
        wr(8'd3, 7'd9, 8'h11, 1, 0, "R3");
        wr(8'd3, 7'd5, 8'h3C, 1, 0, "R3");
        chk(load_cnt == 2, "R3 distinct count", load_cnt, 2);
        // R4 mismatch rejected
        wr(8'd4, 7'd1, 8'h77, 0, 1, "R4");
        chk(load_cnt == 2 && !valid_mask[1], "R4 no load", load_cnt, 2);
        chk(page_addr == 8'd3, "R4 page kept", page_addr, 3);
        // R5 write on the last edge of the window, counted from the rewrite
        idle(W - 2);
        wr(8'd3, 7'h7F, 8'hC3, 1, 0, "R5");
        // R4 mismatch one edge before expiry must not restart the window
        idle(W - 2);
        wr(8'd4, 7'd2, 8'h00, 0, 1, "R4");
        @(negedge clk);
        chk(load_active && !prog_busy, "R5 still loading", prog_busy, 0);
        @(negedge clk);
        chk(prog_busy && prog_start, "R4 R5 expiry on window edge", {prog_busy, prog_start}, 3);
        start_cyc = cyc;
        @(posedge clk);
        #2;
        // R8 write during programming is ignored
        wr(8'd3, 7'd1, 8'h99, 0, 0, "R8");
        chk(!prog_start, "R7 single pulse", prog_start, 0);
        chk(!valid_mask[1], "R8 mask untouched", valid_mask[1], 0);
        wait_busy_end();
        chk(cyc - start_cyc == P, "R7 busy length", cyc - start_cyc, P);
        chk(load_cnt == 0 && valid_mask == '0 && !load_active, "R9 cleared", load_cnt, 0);
        chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

        // R6 load spanning several windows
        @(posedge clk);
        #2;
        wr(8'h21, 7'd0, 8'h01, 1, 0, "R6");
        for (int k = 1; k < 5; k++) begin
            idle(W - 1);
            wr(8'h21, 7'(k), 8'(k), 1, 0, "R6");
        end
        chk(load_active && !prog_busy && load_cnt == 5, "R6 load still open", load_cnt, 5);
        while (!prog_busy) @(negedge clk);
        wait_busy_end();
        @(posedge clk);
        #2;

        // R10 full page
        for (int i = 0; i < PS; i++)
            wr(8'h55, 7'(i), 8'(i) ^ 8'h5A, 1, 0, "R10");
        chk(load_cnt == PS, "R10 full count", load_cnt, PS);
        chk(valid_mask == {PS{1'b1}}, "R10 full mask", $countones(valid_mask), PS);
        chk(page_addr == 8'h55, "R2 page of full load", page_addr, 8'h55);
        while (!prog_busy) @(negedge clk);
        wait_busy_end();
        chk(load_cnt == 0 && valid_mask == '0, "R9 cleared after full page", $countones(valid_mask), 0);
        @(posedge clk);
        #2;
        // R8 a new page locks after programming
        wr(8'h12, 7'd0, 8'hEE, 1, 0, "R8");
        chk(page_addr == 8'h12, "R8 new page lock", page_addr, 8'h12);
        while (!prog_busy) @(negedge clk);
        wait_busy_end();
        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule